// File: doc/BRIEF.md
# Retirement Event Priority Selector

This block sits at the retirement point of a pipelined processor. Event sources (hardware reset request, machine check, init, system management, a trap raised by the previous instruction, a software interrupt instruction, the non-maskable interrupt, the maskable interrupt, an execute-stage fault and a fetch/decode fault) each raise a one-cycle request. Each request sets a pending bit that stays set until its own event is taken.

On every cycle in which `retire_valid` marks an instruction boundary, the block picks the highest-ranked eligible pending event. It clears that event's pending bit. One cycle later it emits a single-cycle `take` pulse. With the pulse come an 8-bit vector number, a class code and the restart PC. Events that were not chosen stay pending and are picked at later boundaries, so events are serviced one at a time and in program order.

The restart PC depends on the class. A fault restarts at the retiring instruction's PC. A trap or an interrupt restarts at the supplied next PC, which already points at a jump target when the retiring instruction jumped. An abort has no precise restart point and is flagged as not restartable.

There is no data stream at this block's edge. Requests, the boundary strobe and the take pulse are plain control pins. Nothing here can stall, and the consumer of `take` must accept it in the cycle it appears.

Top module: `exc_prio_select`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), all pending bits are cleared. On the following cycles `take`, `vec`, `cls`, `restart_pc` and `restartable` are all zero.
- R2: Priority, from highest to lowest:
  1. hardware reset request
  2. machine check
  3. init
  4. system management
  5. trap from the previous instruction
  6. software interrupt
  7. non-maskable interrupt
  8. maskable interrupt
  9. execute fault
  10. fetch/decode fault
- R3: A pending maskable interrupt is not eligible while `int_en` is 0, and it stays pending until it is taken with `int_en` at 1. The non-maskable interrupt and the software interrupt are taken regardless of `int_en`.
- R4: Execute and fetch/decode faults report class 2'b00, and `restart_pc` equals the `retire_pc` sampled at the selecting boundary.
- R5: The trap and the software interrupt report class 2'b01, and `restart_pc` equals the `next_pc` sampled at the selecting boundary. The software interrupt's vector is the `swi_vec` operand captured with its request.
- R6: Init, system management, the non-maskable interrupt and the maskable interrupt report class 2'b11, and `restart_pc` equals the sampled `next_pc`.
- R7: A hardware reset request or a machine check reports class 2'b10, with `restartable` = 0 and `restart_pc` = 0. Every other class reports `restartable` = 1.
- R8: An event is selected only in a cycle where `retire_valid` is 1. `take` then rises for exactly one cycle on the next clock. When `take` is 0, all other outputs are 0.
- R9: Each boundary takes at most one event. Unchosen events remain pending and are taken at later boundaries in priority order.
- R10: Fixed vector codes:

  | Event | Vector |
  |---|---|
  | hardware reset request | 8'hF0 |
  | machine check | 8'h12 |
  | init | 8'hF1 |
  | system management | 8'hF2 |
  | trap | 8'h01 |
  | non-maskable interrupt | 8'h02 |
  | maskable interrupt | 8'h20 |
  | execute fault | 8'h0D |
  | fetch/decode fault | 8'h0E |

- R11: A request that arrives in the same cycle as its own event is taken leaves the event pending, so it is taken again later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retire_valid | input | 1 | Instruction boundary at retirement this cycle |
| int_en | input | 1 | Global maskable-interrupt enable |
| retire_pc | input | PC_W | PC of the retiring instruction |
| next_pc | input | PC_W | PC of the next instruction, jump target if taken |
| req_hwrst | input | 1 | Hardware reset request |
| req_mchk | input | 1 | Machine check request |
| req_init | input | 1 | Init request |
| req_smgmt | input | 1 | System management request |
| req_trap | input | 1 | Trap from the previous instruction |
| req_swi | input | 1 | Software interrupt instruction |
| swi_vec | input | 8 | Vector operand of the software interrupt |
| req_nmi | input | 1 | Non-maskable interrupt |
| req_intr | input | 1 | Maskable interrupt |
| req_xfault | input | 1 | Execute-stage fault |
| req_ffault | input | 1 | Fetch/decode fault |
| take | output | 1 | One-cycle pulse: an event is taken |
| vec | output | 8 | Vector number of the taken event |
| cls | output | 2 | Class: 00 fault, 01 trap, 10 abort, 11 interrupt |
| restart_pc | output | PC_W | PC to resume at |
| restartable | output | 1 | Zero for aborts |

## Verification
The bench drives several events in one burst and watches them drain one per boundary in rank order. A selector that dropped unchosen bits, or took two at once, shows a missing or merged pulse.

It holds a maskable interrupt pending with the enable clear, then sets the enable. A design that lost the bit never takes it, and one that ignored the mask takes it early. It also feeds distinct `retire_pc` and `next_pc` values, so that any swap between fault and trap restart points shows up. It re-requests an event in the very cycle it is taken, to catch a clear that wins over a set.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;

  localparam int NUM_EV = 10;

  localparam int EV_HWRST  = 0;
  localparam int EV_MCHK   = 1;
  localparam int EV_INIT   = 2;
  localparam int EV_SMGMT  = 3;
  localparam int EV_TRAP   = 4;
  localparam int EV_SWI    = 5;
  localparam int EV_NMI    = 6;
  localparam int EV_INTR   = 7;
  localparam int EV_XFAULT = 8;
  localparam int EV_FFAULT = 9;

  typedef enum logic [1:0] {
    CLS_FAULT = 2'b00,
    CLS_TRAP  = 2'b01,
    CLS_ABORT = 2'b10,
    CLS_INTR  = 2'b11
  } ev_cls_e;

  function automatic ev_cls_e ev_class(int idx);
    case (idx)
      EV_HWRST, EV_MCHK:                   return CLS_ABORT;
      EV_TRAP, EV_SWI:                     return CLS_TRAP;
      EV_XFAULT, EV_FFAULT:                return CLS_FAULT;
      default:                             return CLS_INTR;
    endcase
  endfunction

  function automatic logic [7:0] ev_vector(int idx);
    case (idx)
      EV_HWRST:  return 8'hF0;
      EV_MCHK:   return 8'h12;
      EV_INIT:   return 8'hF1;
      EV_SMGMT:  return 8'hF2;
      EV_TRAP:   return 8'h01;
      EV_NMI:    return 8'h02;
      EV_INTR:   return 8'h20;
      EV_XFAULT: return 8'h0D;
      EV_FFAULT: return 8'h0E;
      default:   return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/exc_pend_reg.sv
module exc_pend_reg
  import exc_prio_pkg::*;
#(
  parameter int N     = NUM_EV,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     set_i,
  input  logic [N-1:0]     clr_i,
  input  logic [VEC_W-1:0] swi_vec_i,
  output logic [N-1:0]     pend_o,
  output logic [VEC_W-1:0] swi_vec_o
);

  logic [N-1:0]     pend_q;
  logic [VEC_W-1:0] swv_q;

  // a fresh request wins over the clear of the same bit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      swv_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | set_i;
      if (set_i[EV_SWI]) swv_q <= swi_vec_i;
    end
  end

  assign pend_o    = pend_q;
  assign swi_vec_o = swv_q;

endmodule

// File: rtl/exc_pick.sv
module exc_pick
  import exc_prio_pkg::*;
#(
  parameter int N = NUM_EV
) (
  input  logic [N-1:0] pend_i,
  input  logic         int_en_i,
  input  logic         boundary_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  logic [N-1:0] elig;
  logic [N:0]   above;

  assign above[0] = 1'b0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_rank
      if (i == EV_INTR) begin : g_masked
        assign elig[i] = pend_i[i] & int_en_i & boundary_i;
      end else begin : g_plain
        assign elig[i] = pend_i[i] & boundary_i;
      end
      assign grant_o[i]  = elig[i] & ~above[i];
      assign above[i+1]  = above[i] | elig[i];
    end
  endgenerate

  assign any_o = above[N];

endmodule

// File: rtl/exc_out_stage.sv
module exc_out_stage
  import exc_prio_pkg::*;
#(
  parameter int N     = NUM_EV,
  parameter int PC_W  = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     grant_i,
  input  logic             any_i,
  input  logic [VEC_W-1:0] swi_vec_i,
  input  logic [PC_W-1:0]  retire_pc_i,
  input  logic [PC_W-1:0]  next_pc_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [1:0]       cls_o,
  output logic [PC_W-1:0]  restart_pc_o,
  output logic             restartable_o
);

  logic [VEC_W-1:0] vec_d;
  ev_cls_e          cls_d;
  logic [PC_W-1:0]  pc_d;

  always_comb begin
    vec_d = '0;
    cls_d = CLS_FAULT;
    for (int i = 0; i < N; i++) begin
      if (grant_i[i]) begin
        vec_d = (i == EV_SWI) ? swi_vec_i : VEC_W'(ev_vector(i));
        cls_d = ev_class(i);
      end
    end
    case (cls_d)
      CLS_FAULT: pc_d = retire_pc_i;
      CLS_ABORT: pc_d = '0;
      default:   pc_d = next_pc_i;
    endcase
    if (!any_i) pc_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o        <= 1'b0;
      vec_o         <= '0;
      cls_o         <= '0;
      restart_pc_o  <= '0;
      restartable_o <= 1'b0;
    end else begin
      take_o        <= any_i;
      vec_o         <= any_i ? vec_d : '0;
      cls_o         <= any_i ? cls_d : 2'b00;
      restart_pc_o  <= pc_d;
      restartable_o <= any_i && (cls_d != CLS_ABORT);
    end
  end

endmodule

// File: rtl/exc_prio_select.sv
module exc_prio_select
  import exc_prio_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_valid,
  input  logic            int_en,
  input  logic [PC_W-1:0] retire_pc,
  input  logic [PC_W-1:0] next_pc,
  input  logic            req_hwrst,
  input  logic            req_mchk,
  input  logic            req_init,
  input  logic            req_smgmt,
  input  logic            req_trap,
  input  logic            req_swi,
  input  logic [7:0]      swi_vec,
  input  logic            req_nmi,
  input  logic            req_intr,
  input  logic            req_xfault,
  input  logic            req_ffault,
  output logic            take,
  output logic [7:0]      vec,
  output logic [1:0]      cls,
  output logic [PC_W-1:0] restart_pc,
  output logic            restartable
);

  localparam int N     = NUM_EV;
  localparam int VEC_W = 8;

  logic [N-1:0]     req_bus;
  logic [N-1:0]     pend;
  logic [N-1:0]     grant;
  logic             any_grant;
  logic [VEC_W-1:0] swv;

  always_comb begin
    req_bus            = '0;
    req_bus[EV_HWRST]  = req_hwrst;
    req_bus[EV_MCHK]   = req_mchk;
    req_bus[EV_INIT]   = req_init;
    req_bus[EV_SMGMT]  = req_smgmt;
    req_bus[EV_TRAP]   = req_trap;
    req_bus[EV_SWI]    = req_swi;
    req_bus[EV_NMI]    = req_nmi;
    req_bus[EV_INTR]   = req_intr;
    req_bus[EV_XFAULT] = req_xfault;
    req_bus[EV_FFAULT] = req_ffault;
  end

  exc_pend_reg #(.N(N), .VEC_W(VEC_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (req_bus),
    .clr_i     (grant),
    .swi_vec_i (swi_vec),
    .pend_o    (pend),
    .swi_vec_o (swv)
  );

  exc_pick #(.N(N)) u_pick (
    .pend_i     (pend),
    .int_en_i   (int_en),
    .boundary_i (retire_valid),
    .grant_o    (grant),
    .any_o      (any_grant)
  );

  exc_out_stage #(.N(N), .PC_W(PC_W), .VEC_W(VEC_W)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .grant_i       (grant),
    .any_i         (any_grant),
    .swi_vec_i     (swv),
    .retire_pc_i   (retire_pc),
    .next_pc_i     (next_pc),
    .take_o        (take),
    .vec_o         (vec),
    .cls_o         (cls),
    .restart_pc_o  (restart_pc),
    .restartable_o (restartable)
  );

endmodule

// File: rtl/exc_prio_checker.sv
module exc_prio_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            retire_valid,
  input logic            int_en,
  input logic [PC_W-1:0] retire_pc,
  input logic [PC_W-1:0] next_pc,
  input logic            take,
  input logic [7:0]      vec,
  input logic [1:0]      cls,
  input logic [PC_W-1:0] restart_pc,
  input logic            restartable
);

  p_take_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(retire_valid));

  p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (vec == 8'h00 && cls == 2'b00 && restart_pc == '0 && !restartable));

  p_abort_flagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == 2'b10) |-> (!restartable && restart_pc == '0));

  p_fault_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == 2'b00) |-> (restart_pc == $past(retire_pc) && restartable));

  p_trap_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == 2'b01) |-> restart_pc == $past(next_pc));

  p_intr_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == 2'b11) |-> restart_pc == $past(next_pc));

  p_mask_honoured_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls == 2'b11 && vec == 8'h20) |-> $past(int_en));

endmodule

bind exc_prio_select exc_prio_checker #(.PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .retire_valid (retire_valid),
  .int_en       (int_en),
  .retire_pc    (retire_pc),
  .next_pc      (next_pc),
  .take         (take),
  .vec          (vec),
  .cls          (cls),
  .restart_pc   (restart_pc),
  .restartable  (restartable)
);

// File: tb/tb_exc_prio_select.sv
`timescale 1ns/1ps
module tb_exc_prio_select;

  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire_valid = 1'b0, int_en = 1'b0;
  logic [PC_W-1:0] retire_pc = '0, next_pc = '0;
  logic [9:0] req = '0;
  logic [7:0] swi_vec = '0;
  logic take, restartable;
  logic [7:0] vec;
  logic [1:0] cls;
  logic [PC_W-1:0] restart_pc;

  int checks = 0, failures = 0, cycles = 0;

  always #2 clk = ~clk;

  exc_prio_select #(.PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .int_en(int_en),
    .retire_pc(retire_pc), .next_pc(next_pc),
    .req_hwrst(req[0]), .req_mchk(req[1]), .req_init(req[2]), .req_smgmt(req[3]),
    .req_trap(req[4]), .req_swi(req[5]), .swi_vec(swi_vec), .req_nmi(req[6]),
    .req_intr(req[7]), .req_xfault(req[8]), .req_ffault(req[9]),
    .take(take), .vec(vec), .cls(cls), .restart_pc(restart_pc),
    .restartable(restartable));

  // behavioural reference: index order is rank order (R2)
  bit pend[10];
  logic [7:0] m_swv;
  logic e_take, e_rs;
  logic [7:0] e_vec;
  logic [1:0] e_cls;
  logic [PC_W-1:0] e_pc;

  function automatic logic [7:0] code_of(int i);
    logic [7:0] t[10] = '{8'hF0, 8'h12, 8'hF1, 8'hF2, 8'h01, 8'h00, 8'h02, 8'h20, 8'h0D, 8'h0E};
    return t[i];
  endfunction

  function automatic logic [1:0] cls_of(int i);
    if (i <= 1) return 2'b10;
    if (i == 4 || i == 5) return 2'b01;
    if (i >= 8) return 2'b00;
    return 2'b11;
  endfunction

  always @(posedge clk) begin
    int pick;
    cycles++;
    if (!rst_n) begin
      foreach (pend[k]) pend[k] = 0;
      m_swv = '0;
      e_take = 0; e_vec = '0; e_cls = '0; e_pc = '0; e_rs = 0;
    end else begin
      pick = -1;
      if (retire_valid)
        for (int k = 0; k < 10; k++)
          if (pick < 0 && pend[k] && (k != 7 || int_en)) pick = k;
      e_take = (pick >= 0);
      e_vec = '0; e_cls = '0; e_pc = '0; e_rs = 0;
      if (pick >= 0) begin
        e_vec = (pick == 5) ? m_swv : code_of(pick);
        e_cls = cls_of(pick);
        e_rs  = (e_cls != 2'b10);
        e_pc  = (e_cls == 2'b00) ? retire_pc : (e_cls == 2'b10) ? '0 : next_pc;
        pend[pick] = 0;
      end
      for (int k = 0; k < 10; k++) if (req[k]) pend[k] = 1;
      if (req[5]) m_swv = swi_vec;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string cls_tag(logic [1:0] c);
    case (c)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R7";
      default: return "R6";
    endcase
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk("R8 R9 take", take, e_take);
    chk("R2 R10 vec", vec, e_vec);
    chk({cls_tag(e_cls), " cls"}, cls, e_cls);
    chk({cls_tag(e_cls), " restart_pc"}, restart_pc, e_pc);
    chk("R7 restartable", restartable, e_rs);
  end

  task automatic step(input logic [9:0] r, input logic rv);
    @(negedge clk);
    req = r;
    retire_valid = rv;
    retire_pc = 32'h1000 + $urandom_range(0, 255) * 4;
    next_pc = 32'h8000 + $urandom_range(0, 255) * 4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 take", take, 1'b0);
    chk("R1 vec", vec, 8'h00);
    chk("R1 restart_pc", restart_pc, '0);
    rst_n = 1'b1;
    int_en = 1'b1;

    // R2 R9: full burst drains one per boundary in rank order
    swi_vec = 8'h80;
    step(10'h3FF, 1'b0);
    step('0, 1'b0);
    step('0, 1'b0);   // nothing taken without a boundary (R8)
    for (int k = 0; k < 12; k++) step('0, 1'b1);

    // R3: masked interrupt held, NMI still taken
    int_en = 1'b0;
    step(10'h080, 1'b1);
    for (int k = 0; k < 4; k++) step('0, 1'b1);
    step(10'h040, 1'b1);
    step('0, 1'b1);
    step('0, 1'b1);
    int_en = 1'b1;
    step('0, 1'b1);
    step('0, 1'b1);

    // R4 R5 R6: each class on its own
    step(10'h100, 1'b1); step('0, 1'b1);
    step(10'h200, 1'b1); step('0, 1'b1);
    step(10'h010, 1'b1); step('0, 1'b1);
    swi_vec = 8'h33;
    step(10'h020, 1'b1); step('0, 1'b1);
    step(10'h004, 1'b1); step('0, 1'b1);
    step(10'h002, 1'b1); step('0, 1'b1);

    // R11: re-request in the cycle the event is taken
    step(10'h100, 1'b0);
    step(10'h100, 1'b1);
    step('0, 1'b1);
    step('0, 1'b1);

    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      int_en  = ($urandom_range(0, 3) != 0);
      swi_vec = 8'($urandom_range(0, 255));
      step(($urandom_range(0, 3) == 0) ? 10'($urandom_range(0, 1023)) : 10'h000,
           $urandom_range(0, 1) == 1);
    end
    step('0, 1'b0);
    step('0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule